// File: doc/BRIEF.md
# Page-Buffered Byte-Wide Memory Write Engine

This block models the control side of a byte-wide parallel nonvolatile memory. The three active-low strobes are chip select (`ce_n`), output gate (`oe_n`) and write strobe (`we_n`). They are sampled on a fast system clock. Reads return the addressed byte. Writes do not store at once. Each accepted byte goes into a page buffer and restarts a byte-load window. When the window runs out, a self-timed programming cycle copies the buffer into the register-array store.

While programming runs, every read returns a status byte instead of array data. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips on each new read. The low six bits are zero. A host can therefore poll for the end of the cycle either by comparing against its last byte or by watching for the flipping bit to stop. The full part has 8K locations (`ADDR_W` = 13). The default of 11 keeps the store small when the block is elaborated alone.

States: `ST_IDLE` (buffer empty), `ST_LOAD` (window running, bytes gathering) and `ST_PROG` (timed commit). Transitions: `ST_IDLE`→`ST_LOAD` when the first write completes; `ST_LOAD`→`ST_PROG` when the window expires with no write in progress; `ST_PROG`→`ST_IDLE` after `PROG_CYC` cycles, on the edge that writes the buffer into the store.

Top module: `nvpage_writer`

## Requirements
- R1: `dout_en` is high exactly while `ce_n` and `oe_n` are both low; otherwise it is low, including right after reset. When not programming, `dout` is the store byte at `addr`.
- R2: A write is recognised only while `ce_n` and `we_n` are low and `oe_n` is high. Strobing with `oe_n` low, or with `ce_n` high, changes no stored byte.
- R3: The address is taken on the clock where the write condition becomes true, which is the later falling edge of `ce_n`/`we_n`. The data is taken on the clock where the condition ends, which is the earlier rising edge. Both write-enable-timed and chip-select-timed writes store correctly even when `addr` and `din` change while the strobes are low.
- R4: Address bits [5:0] select the byte within a page and the bits above them select the page. The first byte fixes the page. Up to 64 bytes of that page may be loaded, and a byte for any other page is dropped.
- R5: Each write start restarts the load window. Programming begins `LOAD_CYC` cycles after the last write start, and never while a write is in progress.
- R6: Programming lasts `PROG_CYC` cycles. After it, the loaded bytes read back from the store and the buffer is empty.
- R7: During programming, any read returns a status byte with bit 7 equal to the inverse of bit 7 of the last byte loaded, and bits 5..0 zero.
- R8: During programming, bit 6 of the status differs between successive reads. Once programming ends, reads return true data.
- R9: Write strobes during programming are ignored and do not alter the store.
- R10: Page bytes that were not loaded keep their previous store contents when the page is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data or programming status |
| dout_en | output | 1 | Output driver enable; low means high impedance |

## Verification
Writes are issued with both strobe orderings, and in each one the address and data lines hold wrong values except at the capture edge. A wrong capture point therefore shows up as a wrong stored byte or location. Page tests scatter offsets within one page and add a byte for a foreign page, which separates per-offset placement, page locking and preservation of unloaded bytes. A second byte placed just inside the window shows whether the window restarts: without a restart, a read at that moment would return status instead of the old data. Repeated reads during programming, mixed with a write attempt, separate status generation from true data and confirm that writes in that phase are ignored.

// File: rtl/nvpw_pkg.sv
package nvpw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } nvpw_state_e;
endpackage

// File: rtl/nvpw_strobe.sv
// Strobe decoder: write/read conditions, their edges, address capture.
module nvpw_strobe #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_act,
    output logic              wr_start,
    output logic              wr_end,
    output logic              rd_act,
    output logic              rd_start,
    output logic [ADDR_W-1:0] addr_lat
);
    logic wr_q, rd_q;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign rd_act   = !ce_n && !oe_n;
    assign wr_start = wr_act && !wr_q;
    assign wr_end   = !wr_act && wr_q;
    assign rd_start = rd_act && !rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            addr_lat <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_start) addr_lat <= addr;
        end
    end
endmodule

// File: rtl/nvpw_pagebuf.sv
// Page load buffer with per-byte valid mask and page lock.
module nvpw_pagebuf #(
    parameter int DATA_W = 8,
    parameter int PAGE_BITS = 6,
    parameter int GRP_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [PAGE_BITS-1:0]            off,
    input  logic [GRP_W-1:0]                grp,
    input  logic [DATA_W-1:0]               din,
    input  logic                            clear,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] pbuf,
    output logic [(1<<PAGE_BITS)-1:0]       pmask,
    output logic [GRP_W-1:0]                grp_q,
    output logic [DATA_W-1:0]               last
);
    logic acc;
    assign acc = wr && ((pmask == '0) || (grp == grp_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= '0;
            grp_q <= '0;
            last  <= '0;
        end else if (clear) begin
            pmask <= '0;
        end else if (acc) begin
            pmask[off] <= 1'b1;
            grp_q      <= grp;
            last       <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (acc) pbuf[off] <= din;
    end
endmodule

// File: rtl/nvpw_array.sv
// Register-array store; whole page committed on one edge.
module nvpw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int PAGE_BITS = 6
) (
    input  logic                                  clk,
    input  logic                                  commit,
    input  logic [ADDR_W-PAGE_BITS-1:0]           grp,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] pbuf,
    input  logic [(1<<PAGE_BITS)-1:0]             pmask,
    input  logic [ADDR_W-1:0]                     raddr,
    output logic [DATA_W-1:0]                     rdata
);
    localparam int NWORD = 1 << ADDR_W;
    localparam int NP    = 1 << PAGE_BITS;

    logic [DATA_W-1:0] mem [NWORD];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < NP; i++) begin
                if (pmask[i]) mem[{grp, PAGE_BITS'(i)}] <= pbuf[i];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvpage_writer.sv
module nvpage_writer #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 6,
    parameter int LOAD_CYC  = 5000,
    parameter int PROG_CYC  = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import nvpw_pkg::*;

    localparam int NP    = 1 << PAGE_BITS;
    localparam int GRP_W = ADDR_W - PAGE_BITS;
    localparam int LW    = $clog2(LOAD_CYC + 1);
    localparam int PW    = $clog2(PROG_CYC + 1);

    nvpw_state_e state, nxt;

    logic              wr_act, wr_start, wr_end, rd_act, rd_start;
    logic [ADDR_W-1:0] addr_lat;
    logic              armed, take, load_exp, prog_done, tgl;
    logic [LW-1:0]     load_cnt;
    logic [PW-1:0]     prog_cnt;
    logic [NP-1:0][DATA_W-1:0] pbuf;
    logic [NP-1:0]     pmask;
    logic [GRP_W-1:0]  grp_q;
    logic [DATA_W-1:0] last, rdata, status;

    nvpw_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end),
        .rd_act(rd_act), .rd_start(rd_start), .addr_lat(addr_lat)
    );

    nvpw_pagebuf #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .GRP_W(GRP_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(take),
        .off(addr_lat[PAGE_BITS-1:0]), .grp(addr_lat[ADDR_W-1:PAGE_BITS]),
        .din(din), .clear(prog_done), .pbuf(pbuf), .pmask(pmask),
        .grp_q(grp_q), .last(last)
    );

    nvpw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_mem (
        .clk(clk), .commit(prog_done), .grp(grp_q), .pbuf(pbuf),
        .pmask(pmask), .raddr(addr), .rdata(rdata)
    );

    // a write counts only if it began outside programming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             armed <= 1'b0;
        else if (wr_start && state != ST_PROG)  armed <= 1'b1;
        else if (wr_end)                        armed <= 1'b0;
    end
    assign take = wr_end && armed;

    // load window and programming timers, status toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_cnt <= '0;
            prog_cnt <= '0;
            tgl      <= 1'b0;
        end else begin
            if (wr_start)
                load_cnt <= '0;
            else if (state != ST_PROG && load_cnt != LW'(LOAD_CYC))
                load_cnt <= load_cnt + 1'b1;
            prog_cnt <= (state == ST_PROG) ? prog_cnt + 1'b1 : '0;
            if (state == ST_PROG && rd_start) tgl <= ~tgl;
        end
    end

    assign load_exp  = (load_cnt >= LW'(LOAD_CYC - 1)) && !wr_act && !take;
    assign prog_done = (state == ST_PROG) && (prog_cnt == PW'(PROG_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (take)      nxt = ST_LOAD;
            ST_LOAD: if (load_exp)  nxt = ST_PROG;
            ST_PROG: if (prog_done) nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        status             = '0;
        status[DATA_W-1]   = ~last[DATA_W-1];
        status[DATA_W-2]   = tgl;
        dout_en            = rd_act;
        dout               = (state == ST_PROG) ? status : rdata;
    end
endmodule

// File: rtl/nvpw_check.sv
module nvpw_check #(
    parameter int LOAD_CYC = 5000,
    parameter int PROG_CYC = 250000,
    parameter int NP       = 64,
    parameter int DATA_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_n,
    input logic                  oe_n,
    input logic                  we_n,
    input nvpw_pkg::nvpw_state_e state,
    input logic [NP-1:0]         pmask,
    input logic [DATA_W-1:0]     dout,
    input logic                  dout_en
);
    import nvpw_pkg::*;

    logic in_prog, wa, wa_q;
    int   pc, lc;

    assign in_prog = (state == ST_PROG);
    assign wa      = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= 0; lc <= 0; wa_q <= 1'b0;
        end else begin
            wa_q <= wa;
            pc   <= in_prog ? pc + 1 : 0;
            if (wa && !wa_q)       lc <= 0;
            else if (lc < LOAD_CYC) lc <= lc + 1;
        end
    end

    assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_prog) |-> (lc >= LOAD_CYC));

    assert_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_PROG));

    assert_prog_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_prog) |-> (pc == PROG_CYC));

    assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pmask == '0));

    assert_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && $past(in_prog)) |-> $stable(pmask));

    assert_status_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && dout_en) |-> (dout[5:0] == 6'd0));
endmodule

bind nvpage_writer nvpw_check #(
    .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .NP(NP), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .state(state), .pmask(pmask), .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_nvpage_writer.sv
module sim_nvpage_writer;
    localparam int AW = 11;
    localparam int LC = 24;
    localparam int PC = 40;
    localparam int SETTLE = LC + PC + 10;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0, dout;
    logic          dout_en;
    int            checks = 0, errors = 0;

    nvpage_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_BITS(6),
                    .LOAD_CYC(LC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

    always #2.5 clk = ~clk;

    // {chip-select timed, address, data}
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 11'h012, 8'hA5},
        {1'b1, 11'h013, 8'h5A},
        {1'b0, 11'h7FF, 8'h3C},
        {1'b1, 11'h400, 8'hC3},
        {1'b0, 11'h2C1, 8'h00},
        {1'b1, 11'h2C1, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input bit cemode, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (cemode) begin
            we_n = 1'b0; addr = ~a; din = ~d;
            @(negedge clk); addr = a; ce_n = 1'b0;
            @(negedge clk); addr = ~a;
            @(negedge clk); din = d;
            @(negedge clk); ce_n = 1'b1;
            @(negedge clk); we_n = 1'b1; din = ~d;
        end else begin
            ce_n = 1'b0; addr = a; din = ~d;
            @(negedge clk); we_n = 1'b0;
            @(negedge clk); addr = ~a;
            @(negedge clk); din = d;
            @(negedge clk); we_n = 1'b1;
            @(negedge clk); ce_n = 1'b1; din = ~d;
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic expect_byte(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        logic [7:0] d; logic en;
        do_read(a, d, en);
        chk(en === 1'b1, req, en, 1);
        chk(d === e, req, d, e);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s1, s2, s3, sx; logic e1, e2, e3, ex;

        repeat (3) @(negedge clk);
        chk(dout_en === 1'b0, "R1 reset", dout_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: output gate alone, chip select alone
        oe_n = 1'b0; @(negedge clk);
        chk(dout_en === 1'b0, "R1 ce high", dout_en, 0);
        oe_n = 1'b1; ce_n = 1'b0; @(negedge clk);
        chk(dout_en === 1'b0, "R1 oe high", dout_en, 0);
        ce_n = 1'b1;

        // R3/R6: both strobe orderings, single-byte writes
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][19], VEC[i][18:8], VEC[i][7:0]);
            settle();
            expect_byte(VEC[i][18:8], VEC[i][7:0], "R3 R6 vector");
        end

        // R4: scattered page load plus a foreign-page byte
        do_write(1'b0, 11'h180, 8'h11);
        do_write(1'b1, 11'h185, 8'h22);
        do_write(1'b0, 11'h1BF, 8'h33);
        do_write(1'b1, 11'h191, 8'h44);
        do_write(1'b0, 11'h012, 8'h99);
        settle();
        expect_byte(11'h180, 8'h11, "R4 off0");
        expect_byte(11'h185, 8'h22, "R4 off5");
        expect_byte(11'h1BF, 8'h33, "R4 off63");
        expect_byte(11'h191, 8'h44, "R4 off17");
        expect_byte(11'h012, 8'hA5, "R4 foreign dropped");

        // R10: partial reload keeps the rest of the page
        do_write(1'b0, 11'h185, 8'h77);
        settle();
        expect_byte(11'h185, 8'h77, "R10 reloaded");
        expect_byte(11'h180, 8'h11, "R10 kept0");
        expect_byte(11'h1BF, 8'h33, "R10 kept63");

        // R5: second byte inside the window restarts it
        do_write(1'b0, 11'h013, 8'hE1);
        repeat (10) @(negedge clk);
        do_write(1'b0, 11'h014, 8'hE2);
        repeat (4) @(negedge clk);
        expect_byte(11'h013, 8'h5A, "R5 window restarted");
        settle();
        expect_byte(11'h013, 8'hE1, "R5 first");
        expect_byte(11'h014, 8'hE2, "R5 second");

        // R7/R8/R9: status during programming
        do_write(1'b0, 11'h2C1, 8'h81);
        repeat (LC) @(negedge clk);
        do_read(11'h2C1, s1, e1);
        chk(e1 === 1'b1, "R7 enable", e1, 1);
        chk(s1[7] === 1'b0, "R7 bit7 inverted", s1[7], 0);
        chk(s1[5:0] === 6'd0, "R7 low bits", s1[5:0], 0);
        do_read(11'h2C1, s2, e2);
        chk(s2[6] !== s1[6], "R8 toggle 1", s2[6], ~s1[6]);
        do_read(11'h2C1, s3, e3);
        chk(s3[6] !== s2[6], "R8 toggle 2", s3[6], ~s2[6]);
        do_read(11'h012, sx, ex);
        chk(sx[5:0] === 6'd0 && sx[7] === 1'b0, "R7 other addr", sx, 0);
        do_write(1'b0, 11'h7FF, 8'h00);
        settle();
        expect_byte(11'h2C1, 8'h81, "R8 true data");
        expect_byte(11'h7FF, 8'h3C, "R9 write ignored");

        // R2: blocked write strobes
        @(negedge clk); addr = 11'h012; din = 8'h55;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        settle();
        expect_byte(11'h012, 8'hA5, "R2 blocked");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule